// File: doc/BRIEF.md
# T1 Loopback Mode Router

This block steers bit streams and bit strobes between the four parts of a T1 line transceiver: the receive line interface, the receive framer, the transmit framer and the transmit line interface. Three enable bits select the test loopbacks. Line loopback sends recovered line data straight back to the line. Payload loopback returns the received payload while the overhead bits are inserted locally. Framer loopback feeds the transmit framer's stream into the receive framer. Line coding is reduced to one NRZ data bit and one bipolar-violation flag per bit.

All logic runs on one core clock. Each bit clock is represented as a one-cycle strobe, `rx_tick` or `tx_tick`, and clock selection is a multiplexer on these strobes whose select is registered. A new loopback setting is loaded only at a frame boundary: a strobe together with the frame-start flag of the clock domain that currently drives that direction. This means a frame is never switched partway through. The data multiplexers are combinational from the registered mode, so the selected path shows at the outputs in the cycle after that boundary edge.

Top module: `t1_loop_router`

## Requirements
- R1: After reset no loopback is active. `tx_line_data` follows `tx_ser_data` with `tx_line_bpv` low, `tx_line_tick` follows `tx_tick`, `rx_fr_data`/`rx_fr_bpv` follow `rx_line_data`/`rx_line_bpv`, `rx_clk_out` follows `rx_tick`, and the slot clock and slot block outputs follow their inputs.
- R2: A change on the cfg inputs has no effect until a frame boundary of the governing side. The new mode appears at the outputs in the cycle after the clock edge that sees the boundary.
- R3: In line loopback `tx_line_data` and `tx_line_bpv` equal `rx_line_data` and `rx_line_bpv`, violations kept. `tx_line_tick` follows `rx_tick`, and `tx_ser_data` has no effect on the line.
- R4: In line loopback the receive framer outputs and `rx_clk_out` behave exactly as without loopback.
- R5: In payload loopback without line loopback, `tx_line_data` equals `rx_line_data`, except that where `rx_ovh_slot` is 1 it equals `tx_ovh_bit`. `tx_line_bpv` is 0, `tx_line_tick` follows `rx_tick`, and `tx_ser_data` has no effect.
- R6: While payload loopback is active, `tx_slot_clk_out` and `tx_slot_blk_out` are 0.
- R7: In framer loopback `rx_fr_data` equals `tx_ser_data`, `rx_fr_bpv` is 0 and `rx_clk_out` follows `tx_tick`. The receive line inputs have no effect.
- R8: In framer loopback without line loopback the transmit line carries constant 1 with `tx_line_bpv` 0.
- R9: With framer and line loopback together, the transmit line carries the line loopback data, violations kept.
- R10: With line and payload loopback together, line loopback wins on the transmit line. `rx_ovh_slot` has no effect, violations pass, and the slot outputs stay 0.
- R11: The transmit mode register loads on a receive frame boundary (`rx_tick` and `rx_frame_start`) while line or payload loopback is active, and on a transmit frame boundary otherwise. The receive mode register loads on a transmit frame boundary while framer loopback is active, and on a receive frame boundary otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line_lb | input | 1 | Line loopback enable |
| cfg_pay_lb | input | 1 | Payload loopback enable |
| cfg_frm_lb | input | 1 | Framer loopback enable |
| rx_tick | input | 1 | Recovered receive bit strobe |
| rx_frame_start | input | 1 | Receive bit is first of frame |
| rx_line_data | input | 1 | Recovered receive bit |
| rx_line_bpv | input | 1 | Violation flag of receive bit |
| rx_ovh_slot | input | 1 | Receive bit is an overhead position |
| tx_tick | input | 1 | Transmit bit strobe |
| tx_frame_start | input | 1 | Transmit bit is first of frame |
| tx_ser_data | input | 1 | Transmit framer serial bit |
| tx_ovh_bit | input | 1 | Locally generated overhead bit |
| tx_slot_clk_in | input | 1 | Transmit channel clock |
| tx_slot_blk_in | input | 1 | Transmit channel block marker |
| tx_line_data | output | 1 | Bit to transmit line |
| tx_line_bpv | output | 1 | Violation flag to transmit line |
| tx_line_tick | output | 1 | Transmit line bit strobe |
| tx_slot_clk_out | output | 1 | Gated channel clock |
| tx_slot_blk_out | output | 1 | Gated channel block marker |
| rx_fr_data | output | 1 | Bit to receive framer |
| rx_fr_bpv | output | 1 | Violation flag to receive framer |
| rx_clk_out | output | 1 | Receive bit strobe to system side |

## Verification
A mode change is due in exactly one cycle: the mode register loads on the rising edge that sees the boundary, and the multiplexers have no further register. The bench therefore drives each boundary for one cycle from the falling edge, clears it at the next falling edge, and samples one time unit later. Data and strobe paths are combinational under a fixed mode, so each data pattern is driven at a falling edge and checked before the following rising edge. Boundaries offered on the non-governing side are checked to leave the outputs unchanged in the same slot.

// File: rtl/t1lr_pkg.sv
package t1lr_pkg;
  typedef struct packed {
    logic line;
    logic pay;
    logic frm;
  } lb_mode_t;

  localparam int MODE_W = $bits(lb_mode_t);
  localparam int SLOT_W = 2;
endpackage

// File: rtl/t1lr_mode_hold.sv
module t1lr_mode_hold #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         use_alt,
  input  logic         pri_tick,
  input  logic         pri_fs,
  input  logic         alt_tick,
  input  logic         alt_fs,
  input  logic [W-1:0] cfg_d,
  output logic [W-1:0] mode_q,
  output logic         bnd
);
  logic [W-1:0] mode_d;

  always_comb begin
    bnd    = use_alt ? (alt_tick & alt_fs) : (pri_tick & pri_fs);
    mode_d = mode_q;
    if (bnd) mode_d = cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/t1lr_tx_path.sv
module t1lr_tx_path
  import t1lr_pkg::*;
#(
  parameter int NSLOT = SLOT_W
) (
  input  lb_mode_t          mode,
  input  logic              rx_tick,
  input  logic              tx_tick,
  input  logic              rx_data,
  input  logic              rx_bpv,
  input  logic              ovh_slot,
  input  logic              ovh_bit,
  input  logic              ser_data,
  input  logic [NSLOT-1:0]  slot_in,
  output logic              line_data,
  output logic              line_bpv,
  output logic              line_tick,
  output logic [NSLOT-1:0]  slot_out
);
  logic on_rx_clk;

  always_comb begin
    on_rx_clk = mode.line | mode.pay;
    line_tick = on_rx_clk ? rx_tick : tx_tick;
    line_bpv  = 1'b0;
    if (mode.line) begin
      line_data = rx_data;
      line_bpv  = rx_bpv;
    end else if (mode.frm) begin
      line_data = 1'b1;
    end else if (mode.pay) begin
      line_data = ovh_slot ? ovh_bit : rx_data;
    end else begin
      line_data = ser_data;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot_gate
    assign slot_out[g] = slot_in[g] & ~mode.pay;
  end
endmodule

// File: rtl/t1lr_rx_path.sv
module t1lr_rx_path (
  input  logic frm_on,
  input  logic rx_tick,
  input  logic tx_tick,
  input  logic rx_data,
  input  logic rx_bpv,
  input  logic ser_data,
  output logic fr_data,
  output logic fr_bpv,
  output logic clk_out
);
  always_comb begin
    if (frm_on) begin
      fr_data = ser_data;
      fr_bpv  = 1'b0;
      clk_out = tx_tick;
    end else begin
      fr_data = rx_data;
      fr_bpv  = rx_bpv;
      clk_out = rx_tick;
    end
  end
endmodule

// File: rtl/t1_loop_router.sv
module t1_loop_router
  import t1lr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_line_lb,
  input  logic cfg_pay_lb,
  input  logic cfg_frm_lb,
  input  logic rx_tick,
  input  logic rx_frame_start,
  input  logic rx_line_data,
  input  logic rx_line_bpv,
  input  logic rx_ovh_slot,
  input  logic tx_tick,
  input  logic tx_frame_start,
  input  logic tx_ser_data,
  input  logic tx_ovh_bit,
  input  logic tx_slot_clk_in,
  input  logic tx_slot_blk_in,
  output logic tx_line_data,
  output logic tx_line_bpv,
  output logic tx_line_tick,
  output logic tx_slot_clk_out,
  output logic tx_slot_blk_out,
  output logic rx_fr_data,
  output logic rx_fr_bpv,
  output logic rx_clk_out
);
  logic              rst_meta_q, rst_sync_n;
  lb_mode_t          cfg_mode, tx_mode;
  logic [MODE_W-1:0] tx_mode_bits;
  logic              rx_frm_q;
  logic              tx_bnd, rx_bnd;
  logic [SLOT_W-1:0] slot_in, slot_out;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign cfg_mode = '{line: cfg_line_lb, pay: cfg_pay_lb, frm: cfg_frm_lb};
  assign tx_mode  = lb_mode_t'(tx_mode_bits);

  // transmit direction: governed by the receive clock while line/payload run
  t1lr_mode_hold #(.W(MODE_W)) u_tx_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .use_alt  (tx_mode.line | tx_mode.pay),
    .pri_tick (tx_tick),
    .pri_fs   (tx_frame_start),
    .alt_tick (rx_tick),
    .alt_fs   (rx_frame_start),
    .cfg_d    (cfg_mode),
    .mode_q   (tx_mode_bits),
    .bnd      (tx_bnd)
  );

  // receive direction: governed by the transmit clock while framer loop runs
  t1lr_mode_hold #(.W(1)) u_rx_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .use_alt  (rx_frm_q),
    .pri_tick (rx_tick),
    .pri_fs   (rx_frame_start),
    .alt_tick (tx_tick),
    .alt_fs   (tx_frame_start),
    .cfg_d    (cfg_frm_lb),
    .mode_q   (rx_frm_q),
    .bnd      (rx_bnd)
  );

  assign slot_in = {tx_slot_blk_in, tx_slot_clk_in};

  t1lr_tx_path #(.NSLOT(SLOT_W)) u_tx_path (
    .mode      (tx_mode),
    .rx_tick   (rx_tick),
    .tx_tick   (tx_tick),
    .rx_data   (rx_line_data),
    .rx_bpv    (rx_line_bpv),
    .ovh_slot  (rx_ovh_slot),
    .ovh_bit   (tx_ovh_bit),
    .ser_data  (tx_ser_data),
    .slot_in   (slot_in),
    .line_data (tx_line_data),
    .line_bpv  (tx_line_bpv),
    .line_tick (tx_line_tick),
    .slot_out  (slot_out)
  );

  assign tx_slot_clk_out = slot_out[0];
  assign tx_slot_blk_out = slot_out[1];

  t1lr_rx_path u_rx_path (
    .frm_on   (rx_frm_q),
    .rx_tick  (rx_tick),
    .tx_tick  (tx_tick),
    .rx_data  (rx_line_data),
    .rx_bpv   (rx_line_bpv),
    .ser_data (tx_ser_data),
    .fr_data  (rx_fr_data),
    .fr_bpv   (rx_fr_bpv),
    .clk_out  (rx_clk_out)
  );
endmodule

// File: rtl/t1_loop_router_chk.sv
module t1_loop_router_chk
  import t1lr_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input lb_mode_t tx_mode,
  input logic     rx_frm_q,
  input logic     tx_bnd,
  input logic     rx_bnd,
  input logic     rx_tick,
  input logic     tx_tick,
  input logic     rx_line_data,
  input logic     rx_line_bpv,
  input logic     tx_line_data,
  input logic     tx_line_bpv,
  input logic     tx_line_tick,
  input logic     tx_slot_clk_out,
  input logic     tx_slot_blk_out,
  input logic     rx_clk_out,
  input logic     rx_fr_bpv
);
  // R2
  tx_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bnd |=> $stable(tx_mode));
  // R2
  rx_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_bnd |=> $stable(rx_frm_q));
  // R3
  line_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode.line |-> (tx_line_data == rx_line_data) && (tx_line_bpv == rx_line_bpv)
                     && (tx_line_tick == rx_tick));
  // R5
  pay_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode.pay && !tx_mode.line) |-> !tx_line_bpv && (tx_line_tick == rx_tick));
  // R6
  slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode.pay |-> !tx_slot_clk_out && !tx_slot_blk_out);
  // R7
  frm_rxclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frm_q |-> (rx_clk_out == tx_tick) && !rx_fr_bpv);
  // R8
  frm_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode.frm && !tx_mode.line) |-> tx_line_data && !tx_line_bpv);
endmodule

bind t1_loop_router t1_loop_router_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .tx_mode         (tx_mode),
  .rx_frm_q        (rx_frm_q),
  .tx_bnd          (tx_bnd),
  .rx_bnd          (rx_bnd),
  .rx_tick         (rx_tick),
  .tx_tick         (tx_tick),
  .rx_line_data    (rx_line_data),
  .rx_line_bpv     (rx_line_bpv),
  .tx_line_data    (tx_line_data),
  .tx_line_bpv     (tx_line_bpv),
  .tx_line_tick    (tx_line_tick),
  .tx_slot_clk_out (tx_slot_clk_out),
  .tx_slot_blk_out (tx_slot_blk_out),
  .rx_clk_out      (rx_clk_out),
  .rx_fr_bpv       (rx_fr_bpv)
);

// File: tb/t1_loop_router_tb_top.sv
`timescale 1ns/1ps
module t1_loop_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_line_lb = 0, cfg_pay_lb = 0, cfg_frm_lb = 0;
  logic rx_tick = 0, rx_frame_start = 0, rx_line_data = 0, rx_line_bpv = 0, rx_ovh_slot = 0;
  logic tx_tick = 0, tx_frame_start = 0, tx_ser_data = 0, tx_ovh_bit = 0;
  logic tx_slot_clk_in = 0, tx_slot_blk_in = 0;
  logic tx_line_data, tx_line_bpv, tx_line_tick, tx_slot_clk_out, tx_slot_blk_out;
  logic rx_fr_data, rx_fr_bpv, rx_clk_out;
  int   vectors = 0;
  int   fails = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  t1_loop_router dut_i (.*);

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic rb, input logic ts,
                       input logic rt, input logic tt);
    @(negedge clk);
    rx_line_data = rd; rx_line_bpv = rb; tx_ser_data = ts; rx_tick = rt; tx_tick = tt;
    #1;
  endtask

  task automatic tx_boundary();
    @(negedge clk); tx_tick = 1; tx_frame_start = 1;
    @(negedge clk); tx_tick = 0; tx_frame_start = 0;
    #1;
  endtask

  task automatic rx_boundary();
    @(negedge clk); rx_tick = 1; rx_frame_start = 1;
    @(negedge clk); rx_tick = 0; rx_frame_start = 0;
    #1;
  endtask

  task automatic set_cfg(input logic l, input logic p, input logic f);
    @(negedge clk); cfg_line_lb = l; cfg_pay_lb = p; cfg_frm_lb = f;
  endtask

  task automatic t_reset();
    tx_slot_clk_in = 1; tx_slot_blk_in = 1;
    drive(1, 1, 0, 0, 1);
    chk("R1", "tx_line_data", tx_line_data, 0);
    chk("R1", "tx_line_bpv", tx_line_bpv, 0);
    chk("R1", "tx_line_tick", tx_line_tick, 1);
    chk("R1", "rx_fr_data", rx_fr_data, 1);
    chk("R1", "rx_fr_bpv", rx_fr_bpv, 1);
    chk("R1", "rx_clk_out", rx_clk_out, 0);
    chk("R1", "slot_clk", tx_slot_clk_out, 1);
    chk("R1", "slot_blk", tx_slot_blk_out, 1);
  endtask

  task automatic t_hold_then_line();
    set_cfg(1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      drive(1, 0, 0, i[0], ~i[0]);
      chk("R2", "no boundary yet", tx_line_data, 0);
    end
    // receive boundary does not govern while transmit clock drives the line (R11)
    rx_boundary();
    drive(1, 0, 0, 0, 0);
    chk("R11", "rx boundary ignored", tx_line_data, 0);
    tx_boundary();
    drive(1, 1, 0, 0, 0);
    chk("R2", "line active after boundary", tx_line_data, 1);
  endtask

  task automatic t_line();
    for (int p = 0; p < 4; p++) begin
      drive(p[0], p[1], ~p[0], p[1], ~p[1]);
      chk("R3", "line data", tx_line_data, p[0]);
      chk("R3", "line bpv kept", tx_line_bpv, p[1]);
      chk("R3", "line tick from rx", tx_line_tick, p[1]);
      chk("R4", "rx data normal", rx_fr_data, p[0]);
      chk("R4", "rx bpv normal", rx_fr_bpv, p[1]);
      chk("R4", "rx clk normal", rx_clk_out, p[1]);
    end
  endtask

  task automatic t_pay();
    set_cfg(0, 1, 0);
    tx_boundary();
    drive(0, 1, 1, 0, 0);
    chk("R11", "tx boundary ignored in line lb", tx_line_bpv, 1);
    rx_boundary();
    rx_ovh_slot = 0;
    drive(1, 1, 0, 1, 0);
    chk("R5", "payload data", tx_line_data, 1);
    chk("R5", "payload bpv cleared", tx_line_bpv, 0);
    chk("R5", "payload tick rx", tx_line_tick, 1);
    chk("R6", "slot clk low", tx_slot_clk_out, 0);
    chk("R6", "slot blk low", tx_slot_blk_out, 0);
    @(negedge clk); rx_ovh_slot = 1; tx_ovh_bit = 0;
    drive(1, 0, 1, 0, 1);
    chk("R5", "overhead reinserted", tx_line_data, 0);
    chk("R5", "payload tick not tx", tx_line_tick, 0);
    @(negedge clk); tx_ovh_bit = 1;
    drive(0, 0, 0, 0, 0);
    chk("R5", "overhead one", tx_line_data, 1);
  endtask

  task automatic t_line_pay();
    set_cfg(1, 1, 0);
    rx_boundary();
    @(negedge clk); rx_ovh_slot = 1; tx_ovh_bit = 0;
    drive(1, 1, 0, 1, 0);
    chk("R10", "line wins data", tx_line_data, 1);
    chk("R10", "line wins bpv", tx_line_bpv, 1);
    chk("R10", "slot clk low", tx_slot_clk_out, 0);
    @(negedge clk); rx_ovh_slot = 0;
  endtask

  task automatic t_frm();
    set_cfg(0, 0, 1);
    rx_boundary();
    drive(0, 1, 1, 0, 1);
    chk("R8", "all ones", tx_line_data, 1);
    chk("R8", "no bpv", tx_line_bpv, 0);
    chk("R7", "rx data from tx", rx_fr_data, 1);
    chk("R7", "rx bpv clear", rx_fr_bpv, 0);
    chk("R7", "rx clk from tx", rx_clk_out, 1);
    chk("R6", "slot clk back", tx_slot_clk_out, 1);
    drive(1, 1, 0, 1, 0);
    chk("R7", "rx data ignores line", rx_fr_data, 0);
    chk("R7", "rx clk not rx tick", rx_clk_out, 0);
    set_cfg(0, 0, 0);
    rx_boundary();
    drive(1, 0, 0, 0, 1);
    chk("R11", "rx boundary ignored in framer lb", rx_fr_data, 0);
    chk("R11", "tx side still framer", tx_line_data, 1);
    tx_boundary();
    drive(1, 0, 0, 0, 1);
    chk("R1", "back to normal tx", tx_line_data, 0);
    chk("R1", "back to normal rx", rx_fr_data, 1);
  endtask

  task automatic t_frm_line();
    set_cfg(1, 0, 1);
    tx_boundary();
    rx_boundary();
    drive(0, 1, 1, 0, 1);
    chk("R9", "line data over ones", tx_line_data, 0);
    chk("R9", "line bpv kept", tx_line_bpv, 1);
    chk("R7", "rx data from tx", rx_fr_data, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hold_then_line();
    t_line();
    t_pay();
    t_line_pay();
    t_frm();
    t_frm_line();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule